// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Selector

This block chooses one of two free-running, mutually asynchronous clocks and presents it as a true/complement output pair. When the selection input changes, the output is parked low in a controlled way. The old clock is released only on one of its own falling edges. The new clock is admitted only on one of its own rising edges, once the old one has let go. As a result, no high or low phase during a normal handover is shorter than a half period of the faster source.

For the case where the active or the standby source has died, a force input bypasses the cross-domain handshake. Its rising edge captures the current selection, parks the output low at once (a runt pulse is accepted here), and restarts the output on the captured source. While the force input stays high, neither the select input nor the other clock can disturb the output. Two static overrides sit after the clock path. A gate input parks the pair at a chosen polarity. A power-down input drives both legs of the pair high.

Top module: `glitchfree_clksel`

## Requirements
- R1: With `sel` high the output follows `clk_a1`; with `sel` low it follows `clk_a2`. While active, `qn` is the inverse of `q`.
- R2: After `sel` changes, the final fall of `q` before handover coincides with a falling edge of the previously selected clock. No more than three rising edges of that clock occur between the `sel` change and this fall.
- R3: After that fall, `q` stays low and resumes exactly on a rising edge of the newly selected clock. At most three rising edges of the new clock occur in the low interval, counting the one where `q` rises.
- R4: During normal handovers, no high or low phase of `q` is shorter than the shorter input half-period, and the two per-source enables are never on together.
- R5: On a rising edge of `fsel`, `q` goes low at once and then restarts on a rising edge of the source named by `sel` at that edge, within three of its rising edges. This holds even when the other source has stopped.
- R6: While `fsel` stays high, toggling `sel` or stopping and restarting the deselected clock leaves `q` following the source captured at the `fsel` edge.
- R7: With `pd_n` high and `g` high, `q` equals `gl` and `qn` equals the inverse of `gl`, whatever the clocks are doing. With `g` low, the pair is active again.
- R8: With `pd_n` low, `q` and `qn` are both 1, whatever `g`, `gl` and the clocks are doing.
- R9: While `rst` (active high, synchronous in each clock domain) is high, `q` is 0 and `qn` is 1. After release with `sel` high, `q` stays low through the next rising edge of `clk_a1`. It then first rises exactly on a later rising edge of `clk_a1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a1 | input | 1 | Source clock one, chosen when `sel` is high |
| clk_a2 | input | 1 | Source clock two, chosen when `sel` is low |
| rst | input | 1 | Active-high reset, applied synchronously in each source domain |
| sel | input | 1 | Source choice: 1 selects `clk_a1`, 0 selects `clk_a2` |
| fsel | input | 1 | Force input: rising edge captures `sel` and switches without handshake |
| g | input | 1 | Gate: 1 parks the output pair at the level set by `gl` |
| gl | input | 1 | Parking polarity: `q` takes this value and `qn` its inverse |
| pd_n | input | 1 | Power-down, active low: drives both `q` and `qn` high |
| q | output | 1 | True output clock |
| qn | output | 1 | Complementary output clock |

## Verification
The hardest state to reach from the ports is a dead clock: one source's enable is stuck on while its clock no longer toggles, so the normal handshake can never complete. The stimulus reaches this state by freezing one clock generator low while it is the active source, then moving `sel` and raising `fsel`. The bench then confirms the output restarts on the live source. The two source periods are chosen so their edges never coincide. This lets the bench compute each clock's edge grid and tell, from the time of every output edge, which source edge produced it.

// File: rtl/clkmux_pkg.sv
package clkmux_pkg;

    // Source identifiers; the numeric value doubles as the leg index.
    typedef enum logic {
        SRC_ONE = 1'b0,
        SRC_TWO = 1'b1
    } src_e;

    // One logical output pair.
    typedef struct packed {
        logic hi;   // true leg
        logic lo;   // complementary leg
    } pair_t;

    localparam pair_t PAIR_POWERED_DOWN = '{hi: 1'b1, lo: 1'b1};

    function automatic src_e decode_sel(input logic s);
        return s ? SRC_ONE : SRC_TWO;
    endfunction

    function automatic pair_t park_level(input logic lvl);
        return '{hi: lvl, lo: ~lvl};
    endfunction

    function automatic pair_t drive_clock(input logic c);
        return '{hi: c, lo: ~c};
    endfunction

endpackage

// File: rtl/cm_sync.sv
module cm_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk_i) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cm_leg.sv
// One source domain: synchronizes its requests and the peer's enable,
// and updates its gating enables only while its own clock is low.
module cm_leg #(
    parameter int SYNC     = 2,
    parameter bit START_ON = 1'b0
) (
    input  logic clk_i,
    input  logic rst,
    input  logic req_normal,
    input  logic req_forced,
    input  logic peer_en,
    output logic en_o,
    output logic en_f_o
);
    logic want_s;
    logic peer_s;
    logic forced_s;

    cm_sync #(.STAGES(SYNC), .RST_VAL(START_ON)) u_want (
        .clk_i(clk_i), .rst(rst), .d(req_normal), .q(want_s));

    cm_sync #(.STAGES(SYNC), .RST_VAL(!START_ON)) u_peer (
        .clk_i(clk_i), .rst(rst), .d(peer_en), .q(peer_s));

    cm_sync #(.STAGES(SYNC), .RST_VAL(1'b0)) u_force (
        .clk_i(clk_i), .rst(rst), .d(req_forced), .q(forced_s));

    always_ff @(negedge clk_i) begin
        if (rst) begin
            en_o   <= 1'b0;
            en_f_o <= 1'b0;
        end else begin
            en_o   <= want_s & ~peer_s;
            en_f_o <= forced_s;
        end
    end

    // R2: once the synchronized request drops, the enable is off by the next edge
    p_drop_bound_r2: assert property (@(posedge clk_i) disable iff (rst)
        $fell(want_s) |-> !en_o)
        else $error("enable outlived its request");

    // R5: a withdrawn forced request releases the forced enable in bounded time
    p_force_drop_r5: assert property (@(posedge clk_i) disable iff (rst)
        $fell(forced_s) |-> !en_f_o)
        else $error("forced enable outlived its request");
endmodule

// File: rtl/cm_outstage.sv
module cm_outstage
    import clkmux_pkg::*;
(
    input  logic  core,
    input  logic  g,
    input  logic  gl,
    input  logic  pd_n,
    output pair_t drv
);
    always_comb begin
        if (!pd_n)  drv = PAIR_POWERED_DOWN;
        else if (g) drv = park_level(gl);
        else        drv = drive_clock(core);
    end
endmodule

// File: rtl/glitchfree_clksel.sv
module glitchfree_clksel
    import clkmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_a1,
    input  logic clk_a2,
    input  logic rst,
    input  logic sel,
    input  logic fsel,
    input  logic g,
    input  logic gl,
    input  logic pd_n,
    output logic q,
    output logic qn
);
    localparam int LEGS = 2;

    logic [LEGS-1:0] ck_v;
    logic [LEGS-1:0] en_v;
    logic [LEGS-1:0] enf_v;
    logic [LEGS-1:0] hit_v;
    src_e            pick;
    logic            core;
    pair_t           drv;

    assign ck_v = {clk_a2, clk_a1};

    // Source captured at the force edge; only consulted while fsel is high.
    always_ff @(posedge fsel) begin
        pick <= decode_sel(sel);
    end

    generate
        for (genvar i = 0; i < LEGS; i++) begin : g_leg
            localparam src_e ME = (i == 0) ? SRC_ONE : SRC_TWO;

            assign hit_v[i] = fsel && (pick == ME);

            cm_leg #(.SYNC(SYNC_STAGES), .START_ON(i == 0)) u_leg (
                .clk_i     (ck_v[i]),
                .rst       (rst),
                .req_normal(decode_sel(sel) == ME),
                .req_forced(hit_v[i]),
                .peer_en   (en_v[LEGS-1-i]),
                .en_o      (en_v[i]),
                .en_f_o    (enf_v[i])
            );
        end
    endgenerate

    assign core = fsel ? |(ck_v & enf_v & hit_v) : |(ck_v & en_v);

    cm_outstage u_out (
        .core(core),
        .g   (g),
        .gl  (gl),
        .pd_n(pd_n),
        .drv (drv)
    );

    assign q  = drv.hi;
    assign qn = drv.lo;

    always_comb begin
        if (!rst) begin
            p_one_leg_r4: assert (!(en_v[0] && en_v[1]))
                else $error("both source enables on");
        end
        if (!pd_n) begin
            p_pd_high_r8: assert (q && qn)
                else $error("power-down level wrong");
        end
        if (pd_n && g) begin
            p_gate_level_r7: assert (q == gl && qn == !gl)
                else $error("gate park level wrong");
        end
    end
endmodule

// File: tb/tb_glitchfree_clksel.sv
`timescale 1ns/100ps
module tb_glitchfree_clksel;

    logic clk    = 1'b0;
    logic clk_a1 = 1'b0;
    logic clk_a2 = 1'b0;
    logic rst    = 1'b1;
    logic sel    = 1'b1;
    logic fsel   = 1'b0;
    logic g      = 1'b0;
    logic gl     = 1'b0;
    logic pd_n   = 1'b1;
    logic q, qn;
    bit   run1   = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    glitchfree_clksel dut (
        .clk_a1(clk_a1), .clk_a2(clk_a2), .rst(rst), .sel(sel), .fsel(fsel),
        .g(g), .gl(gl), .pd_n(pd_n), .q(q), .qn(qn));

    // 200 MHz bench clock; sources: 14 ns and 22 ns, edges never coincide.
    always #2.5 clk = ~clk;
    initial forever begin #7; clk_a1 = run1 ? ~clk_a1 : 1'b0; end
    initial begin #1.3; forever begin #11; clk_a2 = ~clk_a2; end end

    function automatic real per(input int i);
        return (i == 1) ? 14.0 : 22.0;
    endfunction
    function automatic real off(input int i, input bit rising);
        if (i == 1) return rising ? 7.0 : 14.0;
        return rising ? 12.3 : 23.3;
    endfunction
    function automatic bit on_edge(input int i, input bit rising, input realtime t);
        real r = (t - off(i, rising)) / per(i);
        real d = r - $floor(r + 0.5);
        return (d * per(i) < 0.01) && (d * per(i) > -0.01);
    endfunction
    // rising/falling edges of source i in (a, b]
    function automatic int edges(input int i, input bit rising, input realtime a, input realtime b);
        return int'($floor((b - off(i, rising)) / per(i))) -
               int'($floor((a - off(i, rising)) / per(i)));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // Output edge tracking and runt monitor
    realtime qf_t   = -100.0;
    realtime last_e = -100.0;
    bit      mon_on = 1'b0;
    int      short_cnt = 0;
    always @(negedge q) qf_t = $realtime;
    always @(q) begin
        if (mon_on && ($realtime - last_e) < 6.99) short_cnt++;
        last_e = $realtime;
    end

    // Scoreboard for static overrides
    typedef struct { string req; logic eq; logic eqn; } exp_t;
    exp_t sbq[$];

    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(q === e.eq && qn === e.eqn, e.req, "override pair {q,qn}",
                  int'({q, qn}), int'({e.eq, e.eqn}));
        end
    end

    task automatic drive_ovr(input logic vg, input logic vgl, input logic vpd,
                             input string req, input int hold);
        @(posedge clk); #0.7;
        g = vg; gl = vgl; pd_n = vpd;
        for (int k = 0; k < hold; k++) begin
            exp_t e;
            e.req = req;
            if (!vpd)    begin e.eq = 1'b1; e.eqn = 1'b1; end
            else if (vg) begin e.eq = vgl;  e.eqn = ~vgl; end
            else         begin e.eq = 1'bx; e.eqn = 1'bx; end
            sbq.push_back(e);
            @(posedge clk);
        end
    endtask

    task automatic follow(input int i, input string req, input int cyc);
        for (int k = 0; k < cyc; k++) begin
            if (i == 1) @(posedge clk_a1); else @(posedge clk_a2);
            #2;
            check(q === 1'b1 && qn === 1'b0, req, "high phase {q,qn}", int'({q, qn}), 2);
            if (i == 1) @(negedge clk_a1); else @(negedge clk_a2);
            #2;
            check(q === 1'b0 && qn === 1'b1, req, "low phase {q,qn}", int'({q, qn}), 1);
        end
    endtask

    // wait for q to rise on a rising edge of source n; returns that time
    task automatic wait_resume(input int n, output bit got, output realtime t);
        got = 1'b0;
        t   = 0.0;
        for (int k = 0; k < 20 && !got; k++) begin
            @(posedge q);
            if (on_edge(n, 1'b1, $realtime)) begin got = 1'b1; t = $realtime; end
        end
    endtask

    task automatic normal_switch(input bit to_one);
        int      o = to_one ? 2 : 1;
        int      n = to_one ? 1 : 2;
        realtime s, tr;
        bit      got;
        @(posedge clk); #0.7;
        sel = to_one;
        s   = $realtime;
        wait_resume(n, got, tr);
        check(got, "R3", "resume on new source rising edge", int'(got), 1);
        check(on_edge(o, 1'b0, qf_t), "R2", "final fall on old falling edge",
              int'(on_edge(o, 1'b0, qf_t)), 1);
        check(edges(o, 1'b1, s, qf_t) >= 1 && edges(o, 1'b1, s, qf_t) <= 3, "R2",
              "old rising edges before park", edges(o, 1'b1, s, qf_t), 3);
        check(edges(n, 1'b1, qf_t, tr) <= 3, "R3", "new rising edges while parked",
              edges(n, 1'b1, qf_t, tr), 3);
        follow(n, "R1", 3);
    endtask

    initial begin : main
        bit      got;
        realtime ts, tr;

        // R9: reset state with both sources running
        repeat (12) @(posedge clk_a2);
        #2;
        check(q === 1'b0 && qn === 1'b1, "R9", "pair during reset", int'({q, qn}), 1);
        @(negedge clk_a1); #2;
        rst = 1'b0;
        @(posedge clk_a1); #2;
        check(q === 1'b0, "R9", "q low at first edge after release", int'(q), 0);
        @(posedge q);
        check(on_edge(1, 1'b1, $realtime), "R9", "first rise on clk_a1 rising edge",
              int'(on_edge(1, 1'b1, $realtime)), 1);
        mon_on = 1'b1;
        follow(1, "R1", 3);

        // Normal handovers at varied phases (R1..R4)
        for (int r = 0; r < 3; r++) begin
            #(3.1 * r + 1.0);
            normal_switch(1'b0);
            #(4.3 * r + 2.0);
            normal_switch(1'b1);
        end
        check(short_cnt == 0, "R4", "runt phases during normal handover", short_cnt, 0);
        mon_on = 1'b0;

        // R5: forced switch while clk_a1 is high and active
        @(posedge clk_a1); #2;
        sel = 1'b0; fsel = 1'b1; ts = $realtime;
        #0.5;
        check(q === 1'b0, "R5", "q low right after force edge", int'(q), 0);
        wait_resume(2, got, tr);
        check(got, "R5", "forced restart on clk_a2 rising edge", int'(got), 1);
        check(edges(2, 1'b1, ts, tr) <= 3, "R5", "clk_a2 edges to forced restart",
              edges(2, 1'b1, ts, tr), 3);

        // R6: deselected source and sel have no effect while fsel held
        @(negedge clk_a1); run1 = 1'b0;
        follow(2, "R6", 2);
        @(posedge clk); #0.7; sel = 1'b1;
        follow(2, "R6", 3);
        run1 = 1'b1;
        follow(2, "R6", 4);

        // Back to normal operation on clk_a1
        @(posedge clk); #0.7; fsel = 1'b0;
        repeat (12) @(posedge clk_a1);
        follow(1, "R1", 2);

        // R5: active clk_a1 dies, recovery through force edge
        @(negedge clk_a1); #0.5; run1 = 1'b0;
        @(posedge clk); #0.7; sel = 1'b0;
        repeat (4) @(posedge clk_a2);
        @(posedge clk); #0.7;
        fsel = 1'b1; ts = $realtime;
        wait_resume(2, got, tr);
        check(got, "R5", "dead-clock recovery on clk_a2 edge", int'(got), 1);
        check(edges(2, 1'b1, ts, tr) <= 3, "R5", "clk_a2 edges to recovery",
              edges(2, 1'b1, ts, tr), 3);
        follow(2, "R5", 2);
        run1 = 1'b1;

        // R7 and R8: static overrides while clocks run
        drive_ovr(1'b1, 1'b1, 1'b1, "R7", 6);
        drive_ovr(1'b1, 1'b0, 1'b1, "R7", 6);
        drive_ovr(1'b0, 1'b1, 1'b0, "R8", 4);
        drive_ovr(1'b1, 1'b0, 1'b0, "R8", 4);
        drive_ovr(1'b1, 1'b1, 1'b0, "R8", 4);
        @(posedge clk); #0.7;
        pd_n = 1'b1; g = 1'b0;
        wait (sbq.size() == 0);
        follow(2, "R7", 2);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule